// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit unsigned operands and a carry-in in one combinational pass, producing a 16-bit sum and a carry-out. The operands are split into four 4-bit slices. Each slice forms its own per-bit generate and propagate terms. From those terms it derives one slice-level generate/propagate pair, along with the carries that feed its upper three bits.

A second lookahead stage takes the four slice pairs and the carry-in. It forms the carries at bit positions 4, 8, 12 and 16 side by side, so no carry passes serially from one slice to the next. Every AND and OR term in the design has at most five inputs. The block holds no state and has no clock or reset. It is meant to sit inside a larger datapath where the sum must settle in a small, width-independent number of gate levels.

Top module: `cla16_two_level`

## Requirements
- R1: For every input combination, {carry_out, sum} equals the 17-bit arithmetic value op_a + op_b + carry_in.
- R2: carry_out is 1 exactly when op_a + op_b + carry_in is at least 65536, including the wrap case 0xFFFF + 0x0001 (sum 0x0000, carry_out 1).
- R3: When every bit position propagates (op_a XOR op_b = 0xFFFF), the carry-in passes straight through. With carry_in 0 the sum is 0xFFFF and carry_out is 0. With carry_in 1 the sum is 0x0000 and carry_out is 1.
- R4: The carry entering each 4-bit slice (bit positions 4, 8 and 12) equals the carry out of the addition of all lower bits. It is visible as the correct value of sum bits 4, 8 and 12 when a lower slice is all ones.
- R5: Each sum bit i equals op_a[i] XOR op_b[i] XOR the carry out of bits 0..i-1 plus carry_in.
- R6: With all inputs at zero the sum is 0x0000 and carry_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the total |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
All-zero inputs show that no carry appears where none should. Operands whose XOR is all ones make every bit propagate, so only the two-level path can carry carry_in the full length; the alternating pairs 0xAAAA/0x5555 and 0x5555/0xAAAA build that case in two different ways. Equal alternating operands such as 0xAAAA + 0xAAAA generate a carry in every other bit with no propagation at all. Low-slice-all-ones plus one (0x000F, 0x00FF, 0x0FFF, 0xFFFF) tests each slice boundary carry in turn, and a few thousand random pairs with random carry-in cover mixed generate and propagate chains.

// File: rtl/cla16_two_level.sv
module cla16_two_level #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  localparam int SLICE  = 4;
  localparam int NSLICE = WIDTH / SLICE;

  logic [WIDTH-1:0]  bit_g, bit_p, bit_c;
  logic [NSLICE-1:0] sl_g, sl_p;
  logic [NSLICE:0]   sl_c;

  assign bit_g = op_a & op_b;
  assign bit_p = op_a ^ op_b;

  // second-level lookahead: slice carries formed side by side, max fan-in 5
  assign sl_c[0] = carry_in;
  assign sl_c[1] = sl_g[0] | (sl_p[0] & carry_in);
  assign sl_c[2] = sl_g[1] | (sl_p[1] & sl_g[0]) | (sl_p[1] & sl_p[0] & carry_in);
  assign sl_c[3] = sl_g[2] | (sl_p[2] & sl_g[1]) | (sl_p[2] & sl_p[1] & sl_g[0])
                 | (sl_p[2] & sl_p[1] & sl_p[0] & carry_in);
  assign sl_c[4] = sl_g[3] | (sl_p[3] & sl_g[2]) | (sl_p[3] & sl_p[2] & sl_g[1])
                 | (sl_p[3] & sl_p[2] & sl_p[1] & sl_g[0])
                 | (sl_p[3] & sl_p[2] & sl_p[1] & sl_p[0] & carry_in);

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    logic [SLICE-1:0] g, p;
    logic             ci, co_local;
    assign g  = bit_g[k*SLICE +: SLICE];
    assign p  = bit_p[k*SLICE +: SLICE];
    assign ci = sl_c[k];

    assign sl_g[k] = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0]);
    assign sl_p[k] = p[3] & p[2] & p[1] & p[0];

    assign bit_c[k*SLICE]     = ci;
    assign bit_c[k*SLICE + 1] = g[0] | (p[0] & ci);
    assign bit_c[k*SLICE + 2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & ci);
    assign bit_c[k*SLICE + 3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & ci);

    // full in-slice carry out, used only to cross-check the second level
    assign co_local = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0])
                    | (p[3] & p[2] & p[1] & p[0] & ci);

    always_comb begin
      assert_slice_carry_R4: assert (co_local == sl_c[k+1])
        else $error("slice %0d carry mismatch", k);
      assert_all_prop_R3: assert (!(sl_p[k] && sl_g[k]))
        else $error("slice %0d both generates and propagates", k);
    end
  end

  assign sum       = bit_p ^ bit_c;
  assign carry_out = sl_c[NSLICE];

  always_comb begin
    assert_total_R1: assert ({carry_out, sum} == ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
      else $error("sum mismatch");
    assert_sum_bit_R5: assert ((sum ^ op_a ^ op_b) == bit_c)
      else $error("sum bit does not match carry");
  end
endmodule

// File: tb/cla16_two_level_test.sv
module cla16_two_level_test;
  logic        clk = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic        cin = 1'b0;
  logic [15:0] s;
  logic        cout;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  cla16_two_level uut (.op_a(a), .op_b(b), .carry_in(cin), .sum(s), .carry_out(cout));

  task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cin=%0d got=%h exp=%h", req, a, b, cin, got, exp);
    end
  endtask

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c, input string req);
    int unsigned total;
    logic [15:0] exp_bits;
    @(posedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
    total = int'(x) + int'(y) + int'(c);
    check(req, {cout, s}, total[16:0]);
    for (int i = 0; i < 16; i++) begin
      int unsigned lo;
      lo = (int'(x) % (1 << i)) + (int'(y) % (1 << i)) + int'(c);
      exp_bits[i] = x[i] ^ y[i] ^ ((lo >> i) & 1);
    end
    check("R5", {1'b0, s}, {1'b0, exp_bits});
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R6", {cout, s}, 17'h0_0000);
    apply(16'hFFFF, 16'h0000, 1'b0, "R3");
    apply(16'hFFFF, 16'h0000, 1'b1, "R3");
    apply(16'hAAAA, 16'h5555, 1'b1, "R3");
    apply(16'h5555, 16'hAAAA, 1'b0, "R3");
    apply(16'hAAAA, 16'hAAAA, 1'b0, "R1");
    apply(16'h5555, 16'h5555, 1'b1, "R1");
    apply(16'h000F, 16'h0001, 1'b0, "R4");
    apply(16'h00FF, 16'h0000, 1'b1, "R4");
    apply(16'h0FFF, 16'h0001, 1'b0, "R4");
    apply(16'hFFFF, 16'h0001, 1'b0, "R2");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R2");
    apply(16'h8000, 16'h8000, 1'b0, "R2");
    for (int i = 0; i < 3000; i++)
      apply(16'($urandom), 16'($urandom), 1'($urandom), "R1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule